// File: doc/BRIEF.md
# Core Operating Mode and Privilege Tracker

This block holds the execution context of a small microcontroller core. The core runs in one of two modes: thread mode for ordinary code, and handler mode for exception and interrupt service. Separately, it tracks whether thread-mode code runs with privileged or unprivileged access. The block also records the number of the exception being serviced and holds a single mask bit. When that bit is set, the core's exception arbiter must not activate any exception whose priority is configurable.

The surrounding core drives the inputs. It pulses `exc_entry` with the exception number when it takes an exception, and pulses `exc_return` when a handler finishes. It drives the two write ports when software updates the privilege-control bit or the mask bit. Every input is a single-cycle control strobe with no data stream, so the block has no valid/ready handshake. It cannot stall, every strobe is acted on in the cycle it is seen, and every output is registered state or a gate of registered state.

Handler mode always has full access, whatever the stored thread privilege says. Thread code may give up privilege, but cannot take it back. Only handler code can rewrite the stored bit so that a later return lands in privileged thread mode.

Top module: `mode_priv_ctrl`

## Requirements
- R1: After reset the block is in thread mode (`mode_handler`=0) with `priv_eff`=1, `active_exc`=0 and `cfg_exc_block`=0.
- R2: A cycle with `exc_entry`=1 puts the block in handler mode on the next clock edge, with `active_exc` equal to the `exc_num` sampled with the strobe.
- R3: While `mode_handler`=1, `priv_eff` is 1 regardless of the stored thread privilege bit.
- R4: In privileged thread mode, a write to the privilege-control port with `ctrl_wdata`=1 (1 means unprivileged) makes `priv_eff` 0 from the next edge.
- R5: In unprivileged thread mode, a privilege-control write with `ctrl_wdata`=0 is dropped and `priv_eff` stays 0.
- R6: In handler mode, privilege-control writes update the stored thread bit. After the next return, `priv_eff` equals the inverse of the last value written.
- R7: `exc_return`=1 without `exc_entry` puts the block in thread mode on the next edge. `active_exc` becomes 0 and `priv_eff` follows the stored thread bit.
- R8: A mask write (`mask_we`=1) while `priv_eff`=1 sets `cfg_exc_block` to `mask_wdata` from the next edge.
- R9: A mask write while `priv_eff`=0 is dropped and `cfg_exc_block` keeps its value.
- R10: A privilege-control write in the same cycle as `exc_entry` is discarded. The exception entry still takes effect.
- R11: When `exc_entry` and `exc_return` are both high, entry wins: the block ends in handler mode with the new number.
- R12: An `exc_entry` while already in handler mode replaces `active_exc` with the new number and keeps handler mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_entry | input | 1 | Exception taken this cycle |
| exc_num | input | EXC_W | Exception number accompanying `exc_entry` |
| exc_return | input | 1 | Handler finished this cycle |
| ctrl_we | input | 1 | Privilege-control write strobe |
| ctrl_wdata | input | 1 | New thread privilege bit, 1 = unprivileged |
| mask_we | input | 1 | Mask bit write strobe |
| mask_wdata | input | 1 | New mask bit value |
| mode_handler | output | 1 | 1 in handler mode, 0 in thread mode |
| priv_eff | output | 1 | Effective privilege, 1 = privileged |
| active_exc | output | EXC_W | Number of the exception being serviced, 0 in thread mode |
| cfg_exc_block | output | 1 | Blocks activation of configurable-priority exceptions |

## Verification
The bench tries to climb back to privilege from unprivileged thread code. A design that honoured that write would hand full access to untrusted code. It also sends unprivileged mask writes, which a faulty design would let switch interrupt blocking on or off. The bench collides exception entry with a privilege drop and with a return in the same cycle. A wrong priority would leave the core in thread mode or lose the drop-discard rule. Finally, it checks that the stored bit written inside a handler governs the privilege after the return, and that nested entries overwrite the recorded exception number.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
  typedef enum logic {
    MODE_THREAD  = 1'b0,
    MODE_HANDLER = 1'b1
  } mode_e;
endpackage

// File: rtl/mpc_mode_track.sv
// Holds operating mode and the number of the exception being serviced.
module mpc_mode_track
  import mpc_pkg::*;
#(
  parameter int EXC_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exc_entry,
  input  logic             exc_return,
  input  logic [EXC_W-1:0] exc_num,
  output mode_e            mode_q,
  output logic [EXC_W-1:0] act_q
);
  localparam logic [EXC_W-1:0] NO_EXC = '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_THREAD;
      act_q  <= NO_EXC;
    end else if (exc_entry) begin
      // entry outranks a simultaneous return
      mode_q <= MODE_HANDLER;
      act_q  <= exc_num;
    end else if (exc_return) begin
      mode_q <= MODE_THREAD;
      act_q  <= NO_EXC;
    end
  end
endmodule

// File: rtl/mpc_priv_reg.sv
// Stored thread privilege bit (1 = unprivileged thread code).
module mpc_priv_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic exc_entry,
  input  logic wr_en,
  input  logic wr_unpriv,
  input  logic priv_eff,
  output logic unpriv_q
);
  logic accept;

  // unprivileged writers are ignored; exception entry discards the write
  assign accept = wr_en & priv_eff & ~exc_entry;

  always_ff @(posedge clk) begin
    if (!rst_n)      unpriv_q <= 1'b0;
    else if (accept) unpriv_q <= wr_unpriv;
  end
endmodule

// File: rtl/mpc_mask_reg.sv
// Mask bit that blocks configurable-priority exceptions.
module mpc_mask_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_val,
  input  logic priv_eff,
  output logic mask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)                 mask_q <= 1'b0;
    else if (wr_en && priv_eff) mask_q <= wr_val;
  end
endmodule

// File: rtl/mode_priv_ctrl.sv
module mode_priv_ctrl
  import mpc_pkg::*;
#(
  parameter int EXC_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exc_entry,
  input  logic [EXC_W-1:0] exc_num,
  input  logic             exc_return,
  input  logic             ctrl_we,
  input  logic             ctrl_wdata,
  input  logic             mask_we,
  input  logic             mask_wdata,
  output logic             mode_handler,
  output logic             priv_eff,
  output logic [EXC_W-1:0] active_exc,
  output logic             cfg_exc_block
);
  mode_e mode_q;
  logic  unpriv_q;

  mpc_mode_track #(.EXC_W(EXC_W)) u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .exc_entry  (exc_entry),
    .exc_return (exc_return),
    .exc_num    (exc_num),
    .mode_q     (mode_q),
    .act_q      (active_exc)
  );

  mpc_priv_reg u_priv (
    .clk       (clk),
    .rst_n     (rst_n),
    .exc_entry (exc_entry),
    .wr_en     (ctrl_we),
    .wr_unpriv (ctrl_wdata),
    .priv_eff  (priv_eff),
    .unpriv_q  (unpriv_q)
  );

  mpc_mask_reg u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (mask_we),
    .wr_val   (mask_wdata),
    .priv_eff (priv_eff),
    .mask_q   (cfg_exc_block)
  );

  // handler mode always runs privileged
  assign mode_handler = (mode_q == MODE_HANDLER);
  assign priv_eff     = mode_handler | ~unpriv_q;
endmodule

// File: rtl/mpc_chk.sv
module mpc_chk #(
  parameter int EXC_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             exc_entry,
  input logic [EXC_W-1:0] exc_num,
  input logic             exc_return,
  input logic             ctrl_we,
  input logic             ctrl_wdata,
  input logic             mask_we,
  input logic             mask_wdata,
  input logic             mode_handler,
  input logic             priv_eff,
  input logic [EXC_W-1:0] active_exc,
  input logic             cfg_exc_block
);
  // R2
  entry_to_handler_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_entry |=> mode_handler && active_exc == $past(exc_num));

  // R7
  return_to_thread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_return && !exc_entry |=> !mode_handler && active_exc == '0);

  // R5
  no_priv_regain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !priv_eff && !exc_entry |=> !priv_eff);

  // R9
  unpriv_mask_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !priv_eff && mask_we |=> $stable(cfg_exc_block));

  // R8
  priv_mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    priv_eff && mask_we |=> cfg_exc_block == $past(mask_wdata));

  // R7
  thread_zero_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_handler |-> active_exc == '0);
endmodule

bind mode_priv_ctrl mpc_chk #(.EXC_W(EXC_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .exc_entry     (exc_entry),
  .exc_num       (exc_num),
  .exc_return    (exc_return),
  .ctrl_we       (ctrl_we),
  .ctrl_wdata    (ctrl_wdata),
  .mask_we       (mask_we),
  .mask_wdata    (mask_wdata),
  .mode_handler  (mode_handler),
  .priv_eff      (priv_eff),
  .active_exc    (active_exc),
  .cfg_exc_block (cfg_exc_block)
);

// File: tb/sim_mode_priv_ctrl.sv
`timescale 1ns/1ps
module sim_mode_priv_ctrl;
  localparam int EXC_W = 9;
  localparam int NV    = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exc_entry = 1'b0, exc_return = 1'b0;
  logic [EXC_W-1:0] exc_num = '0;
  logic ctrl_we = 1'b0, ctrl_wdata = 1'b0, mask_we = 1'b0, mask_wdata = 1'b0;
  logic mode_handler, priv_eff, cfg_exc_block;
  logic [EXC_W-1:0] active_exc;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  mode_priv_ctrl #(.EXC_W(EXC_W)) u0 (.*);

  // vector: req, entry, ret, num, cwe, cwd, mwe, mwd | exp mode, priv, act, mask
  function automatic logic [30:0] mk(input int rq, input bit en, input bit rt,
      input int num, input bit cwe, input bit cwd, input bit mwe, input bit mwd,
      input bit em, input bit ep, input int ea, input bit emk);
    return {4'(rq), en, rt, 9'(num), cwe, cwd, mwe, mwd, em, ep, 9'(ea), emk};
  endfunction

  localparam logic [30:0] VEC [NV] = '{
    mk(8, 0,0, 0, 0,0, 1,1, 0,1, 0,1),   // R8 privileged mask set
    mk(8, 0,0, 0, 0,0, 1,0, 0,1, 0,0),   // R8 privileged mask clear
    mk(4, 0,0, 0, 1,1, 0,0, 0,0, 0,0),   // R4 drop privilege
    mk(5, 0,0, 0, 1,0, 0,0, 0,0, 0,0),   // R5 regain attempt ignored
    mk(9, 0,0, 0, 0,0, 1,1, 0,0, 0,0),   // R9 unprivileged mask write dropped
    mk(3, 1,0,15, 0,0, 0,0, 1,1,15,0),   // R2 R3 entry, handler privileged
    mk(8, 0,0, 0, 0,0, 1,1, 1,1,15,1),   // R8 mask write inside handler
    mk(6, 0,0, 0, 1,0, 0,0, 1,1,15,1),   // R6 restore thread privilege
    mk(7, 0,1, 0, 0,0, 0,0, 0,1, 0,1),   // R7 R6 return privileged
    mk(4, 0,0, 0, 1,1, 0,0, 0,0, 0,1),   // R4 drop again
    mk(10,1,0, 3, 1,0, 0,0, 1,1, 3,1),   // R10 entry plus write, write lost
    mk(12,1,0,40, 0,0, 0,0, 1,1,40,1),   // R12 nested entry
    mk(10,0,1, 0, 0,0, 0,0, 0,0, 0,1),   // R10 R7 return stays unprivileged
    mk(11,1,1, 7, 0,0, 0,0, 1,1, 7,1),   // R11 entry beats return
    mk(6, 0,0, 0, 1,1, 0,0, 1,1, 7,1),   // R6 R3 handler sets unpriv bit
    mk(11,1,1, 9, 0,0, 0,0, 1,1, 9,1),   // R11 collision in handler
    mk(6, 0,1, 0, 0,0, 0,0, 0,0, 0,1),   // R6 return unprivileged
    mk(9, 0,0, 0, 0,0, 1,0, 0,0, 0,1)    // R9 unprivileged clear dropped
  };

  task automatic check(input string rq, input bit em, input bit ep,
                       input logic [EXC_W-1:0] ea, input bit emk);
    n_chk++;
    if (mode_handler !== em || priv_eff !== ep || active_exc !== ea || cfg_exc_block !== emk) begin
      n_fail++;
      $display("FAIL %s: got mode=%0b priv=%0b exc=%0d mask=%0b, expected mode=%0b priv=%0b exc=%0d mask=%0b",
               rq, mode_handler, priv_eff, active_exc, cfg_exc_block, em, ep, ea, emk);
    end
  endtask

  task automatic step(input bit en, input bit rt, input int num, input bit cwe,
                      input bit cwd, input bit mwe, input bit mwd);
    @(negedge clk);
    exc_entry = en; exc_return = rt; exc_num = EXC_W'(num);
    ctrl_we = cwe; ctrl_wdata = cwd; mask_we = mwe; mask_wdata = mwd;
    @(posedge clk);
    #1;
    exc_entry = 0; exc_return = 0; ctrl_we = 0; mask_we = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(posedge clk); @(posedge clk); #1;
    rst_n = 1;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    check("R1", 0, 1, 0, 0);
    for (int i = 0; i < NV; i++) begin
      logic [30:0] v;
      v = VEC[i];
      step(v[26], v[25], int'(v[24:16]), v[15], v[14], v[13], v[12]);
      check($sformatf("R%0d vec%0d", v[30:27], i), v[11], v[10], v[9:1], v[0]);
    end
    // R1 mid-run reset from unprivileged thread state with mask set
    do_reset();
    check("R1 rerun", 0, 1, 0, 0);
    // R10 drop request colliding with entry in privileged thread
    step(1, 0, 5, 1, 1, 0, 0);
    check("R10 collide", 1, 1, 5, 0);
    step(0, 1, 0, 0, 0, 0, 0);
    check("R10 drop discarded", 0, 1, 0, 0);
    // R3 handler privileged even with stored bit unprivileged
    step(0, 0, 0, 1, 1, 0, 0);
    check("R4 drop", 0, 0, 0, 0);
    step(1, 0, 511, 0, 0, 0, 0);
    check("R3 R2 max number", 1, 1, 511, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    check("R3 holds", 1, 1, 511, 0);
    step(0, 1, 0, 0, 0, 0, 0);
    check("R7 back unprivileged", 0, 0, 0, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule